// File: doc/BRIEF.md
# Write-Back Write-Allocate Data Cache Controller

This block is a direct-mapped data cache controller that sits between a processor's byte load/store port and a block-oriented memory port. Each cache line has a valid flag, a dirty flag, a tag and one block of data. Loads and stores are taken one at a time. A hit is served from the line. A miss first writes a dirty victim back to memory, then reads the whole block in, and then finishes the access against the refilled line.

By default the controller runs write-back and write-allocate. A store that hits changes only the cache and marks the line dirty. Memory sees the new data only when that line is evicted. A store that misses allocates the line from memory first and then merges its byte into it. A compile-time parameter selects write-through instead. In that mode every store also sends its single byte to memory, no line is ever dirty, and evictions never write. Two traffic counters report completed block reads and completed memory writes, so the memory traffic can be compared against a model.

The processor side uses a ready/valid request and a one-cycle response. The memory side holds a request until the memory acknowledges it. Read data arrives together with the acknowledge.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `req_ready_o` is 1, `resp_valid_o` and `mem_req_o` are 0, and both traffic counters are 0.
- R2: A load that hits returns the processor's current view of the addressed byte on `resp_rdata_o` and causes no memory transaction.
- R3: Any miss issues exactly one block read (`mem_we_o` = 0) at block address `req_addr[ADDR_W-1:OFFSET_W]`. Afterwards the line holds that block, is valid and is clean, and a load returns the byte at offset `addr[OFFSET_W-1:0]` of the block, with byte k at `mem_rdata_i[8k+7:8k]`.
- R4: In write-back mode a store hit updates only the cached byte and marks the line dirty. The backing memory byte keeps its old value until the line is evicted.
- R5: In write-back mode, a miss whose victim is valid and dirty first writes the whole victim block (all `mem_be_o` bits set) to the victim's own block address. The block read for the new line follows it. The written data matches the processor's view of that block.
- R6: A victim that is clean, or a line that is invalid, is replaced without any memory write.
- R7: A store miss allocates the line from memory and then merges the stored byte into it. The other bytes of the block keep their memory values.
- R8: With `WRITE_THROUGH` = 1 every store issues one memory write of its block with exactly one `mem_be_o` bit set (bit = byte offset), and an eviction never writes memory.
- R9: Once `mem_req_o` is raised, it and `mem_we_o` and `mem_addr_o` stay constant until the cycle in which `mem_ack_i` is 1.
- R10: `rd_cnt_o` increases by one for each acknowledged block read, and `wr_cnt_o` by one for each acknowledged memory write. Neither changes otherwise.
- R11: A request is accepted only when `req_ready_o` is 1, which holds only while idle. `resp_valid_o` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 8 | Store byte |
| req_ready_o | output | 1 | Controller idle and able to accept |
| resp_valid_o | output | 1 | Access complete (one cycle) |
| resp_rdata_o | output | 8 | Addressed byte of the line |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 = write, 0 = block read |
| mem_addr_o | output | ADDR_W-OFFSET_W | Block address |
| mem_be_o | output | 2**OFFSET_W | Byte enables for writes |
| mem_wdata_o | output | 8*2**OFFSET_W | Write block |
| mem_rdata_i | input | 8*2**OFFSET_W | Read block, valid with acknowledge |
| mem_ack_i | input | 1 | Memory transaction done |
| rd_cnt_o | output | CNT_W | Completed block reads |
| wr_cnt_o | output | CNT_W | Completed memory writes |

## Verification
The bench builds two copies with ADDR_W = 8, OFFSET_W = 2 and INDEX_W = 2. One uses WRITE_THROUGH = 0 and the other WRITE_THROUGH = 1, and both receive the same access sequence. The small geometry (four lines of four bytes, sixteen tags) makes tag conflicts easy to create on purpose. That covers dirty and clean evictions, store misses that evict a dirty line, and re-reads of evicted data. The two variants can then be compared on memory contents and on the traffic counters.

// File: rtl/wb_cache_pkg.sv
package wb_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_WRITEBACK,
    ST_REFILL,
    ST_WTHRU,
    ST_RESPOND
  } cache_state_e;
endpackage

// File: rtl/wb_tag_store.sv
module wb_tag_store #(
  parameter int INDEX_W   = 2,
  parameter int TAG_W     = 4,
  parameter bit HAS_DIRTY = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INDEX_W-1:0] idx_i,
  input  logic               we_i,
  input  logic               valid_i,
  input  logic               dirty_i,
  input  logic [TAG_W-1:0]   tag_i,
  output logic               valid_o,
  output logic               dirty_o,
  output logic [TAG_W-1:0]   tag_o
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (we_i) begin
      valid_q[idx_i] <= valid_i;
      tag_q[idx_i]   <= tag_i;
    end
  end

  assign valid_o = valid_q[idx_i];
  assign tag_o   = tag_q[idx_i];

  generate
    if (HAS_DIRTY) begin : g_dirty
      logic [LINES-1:0] dirty_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   dirty_q <= '0;
        else if (we_i) dirty_q[idx_i] <= dirty_i;
      end
      assign dirty_o = dirty_q[idx_i];
    end else begin : g_no_dirty
      logic unused_dirty;
      assign unused_dirty = dirty_i;
      assign dirty_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wb_data_store.sv
module wb_data_store #(
  parameter int INDEX_W  = 2,
  parameter int OFFSET_W = 2,
  localparam int LINE_W  = 8 * (1 << OFFSET_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [INDEX_W-1:0]  idx_i,
  input  logic                fill_en_i,
  input  logic [LINE_W-1:0]   fill_data_i,
  input  logic                byte_we_i,
  input  logic [OFFSET_W-1:0] byte_off_i,
  input  logic [7:0]          byte_data_i,
  output logic [LINE_W-1:0]   line_o
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINE_W-1:0] line_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) line_q[i] <= '0;
    end else if (fill_en_i) begin
      line_q[idx_i] <= fill_data_i;
    end else if (byte_we_i) begin
      line_q[idx_i][{byte_off_i, 3'b000} +: 8] <= byte_data_i;
    end
  end

  assign line_o = line_q[idx_i];
endmodule

// File: rtl/wb_traffic_cnt.sv
module wb_traffic_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_inc_i,
  input  logic             wr_inc_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic [CNT_W-1:0] wr_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_o <= '0;
      wr_cnt_o <= '0;
    end else begin
      if (rd_inc_i) rd_cnt_o <= rd_cnt_o + 1'b1;
      if (wr_inc_i) wr_cnt_o <= wr_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import wb_cache_pkg::*;
#(
  parameter int  ADDR_W        = 8,
  parameter int  OFFSET_W      = 2,
  parameter int  INDEX_W       = 2,
  parameter int  CNT_W         = 16,
  parameter bit  WRITE_THROUGH = 1'b0,
  localparam int BB            = 1 << OFFSET_W,
  localparam int LINE_W        = 8 * BB,
  localparam int TAG_W         = ADDR_W - INDEX_W - OFFSET_W,
  localparam int BLK_W         = ADDR_W - OFFSET_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_wdata_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic [7:0]        resp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [BLK_W-1:0]  mem_addr_o,
  output logic [BB-1:0]     mem_be_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic [LINE_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic [CNT_W-1:0]  wr_cnt_o
);
  cache_state_e state_q, state_d;

  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [7:0]        wdata_q;

  logic [INDEX_W-1:0]  idx;
  logic [TAG_W-1:0]    tag;
  logic [OFFSET_W-1:0] off;

  assign idx = addr_q[OFFSET_W +: INDEX_W];
  assign tag = addr_q[ADDR_W-1 -: TAG_W];
  assign off = addr_q[OFFSET_W-1:0];

  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic [LINE_W-1:0] line_data;
  logic              hit;

  logic             ts_we, ts_valid, ts_dirty;
  logic [TAG_W-1:0] ts_tag;
  logic             ds_fill, ds_byte_we;

  assign hit = line_valid && (line_tag == tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        addr_q  <= req_addr_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  // next state and line bookkeeping
  always_comb begin
    state_d    = state_q;
    ts_we      = 1'b0;
    ts_valid   = line_valid;
    ts_dirty   = line_dirty;
    ts_tag     = line_tag;
    ds_fill    = 1'b0;
    ds_byte_we = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (hit) begin
          if (we_q) begin
            ds_byte_we = 1'b1;
            ts_we      = 1'b1;
            ts_dirty   = !WRITE_THROUGH;
            state_d    = WRITE_THROUGH ? ST_WTHRU : ST_RESPOND;
          end else begin
            state_d = ST_RESPOND;
          end
        end else if (!WRITE_THROUGH && line_valid && line_dirty) begin
          state_d = ST_WRITEBACK;
        end else begin
          // clean or empty victim: drop it without memory traffic
          ts_we    = line_valid;
          ts_valid = 1'b0;
          ts_dirty = 1'b0;
          state_d  = ST_REFILL;
        end
      end
      ST_WRITEBACK: if (mem_ack_i) begin
        ts_we    = 1'b1;
        ts_valid = 1'b0;
        ts_dirty = 1'b0;
        state_d  = ST_REFILL;
      end
      ST_REFILL: if (mem_ack_i) begin
        ds_fill  = 1'b1;
        ts_we    = 1'b1;
        ts_valid = 1'b1;
        ts_dirty = 1'b0;
        ts_tag   = tag;
        state_d  = ST_COMPARE;
      end
      ST_WTHRU:   if (mem_ack_i) state_d = ST_RESPOND;
      ST_RESPOND: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  wb_tag_store #(
    .INDEX_W  (INDEX_W),
    .TAG_W    (TAG_W),
    .HAS_DIRTY(!WRITE_THROUGH)
  ) u_tags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (idx),
    .we_i   (ts_we),
    .valid_i(ts_valid),
    .dirty_i(ts_dirty),
    .tag_i  (ts_tag),
    .valid_o(line_valid),
    .dirty_o(line_dirty),
    .tag_o  (line_tag)
  );

  wb_data_store #(
    .INDEX_W (INDEX_W),
    .OFFSET_W(OFFSET_W)
  ) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (idx),
    .fill_en_i  (ds_fill),
    .fill_data_i(mem_rdata_i),
    .byte_we_i  (ds_byte_we),
    .byte_off_i (off),
    .byte_data_i(wdata_q),
    .line_o     (line_data)
  );

  assign mem_req_o   = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL) ||
                       (state_q == ST_WTHRU);
  assign mem_we_o    = (state_q == ST_WRITEBACK) || (state_q == ST_WTHRU);
  assign mem_addr_o  = (state_q == ST_WRITEBACK) ? {line_tag, idx} : {tag, idx};
  assign mem_be_o    = (state_q == ST_WTHRU) ? (BB'(1) << off) : {BB{1'b1}};
  assign mem_wdata_o = line_data;

  assign req_ready_o  = (state_q == ST_IDLE);
  assign resp_valid_o = (state_q == ST_RESPOND);
  assign resp_rdata_o = line_data[{off, 3'b000} +: 8];

  wb_traffic_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_inc_i(mem_req_o && !mem_we_o && mem_ack_i),
    .wr_inc_i(mem_req_o && mem_we_o && mem_ack_i),
    .rd_cnt_o(rd_cnt_o),
    .wr_cnt_o(wr_cnt_o)
  );
endmodule

// File: rtl/wb_cache_chk.sv
module wb_cache_chk #(
  parameter int BLK_W         = 6,
  parameter int BB            = 4,
  parameter int CNT_W         = 16,
  parameter bit WRITE_THROUGH = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             resp_valid_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [BLK_W-1:0] mem_addr_o,
  input logic [BB-1:0]    mem_be_o,
  input logic             mem_ack_i,
  input logic [CNT_W-1:0] rd_cnt_o,
  input logic [CNT_W-1:0] wr_cnt_o
);
  logic rd_done, wr_done;
  assign rd_done = mem_req_o && !mem_we_o && mem_ack_i;
  assign wr_done = mem_req_o && mem_we_o && mem_ack_i;

  AST_MEM_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o))); // R9
  AST_RESP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o || mem_req_o) |-> !req_ready_o); // R11
  AST_WB_FULL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!WRITE_THROUGH && mem_req_o && mem_we_o) |-> (&mem_be_o)); // R5
  AST_REFILL_AFTER_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!WRITE_THROUGH && wr_done) |=> (mem_req_o && !mem_we_o)); // R5
  AST_WT_ONE_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WRITE_THROUGH && mem_req_o && mem_we_o) |-> ($countones(mem_be_o) == 1)); // R8
  AST_RD_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done |=> (rd_cnt_o == CNT_W'($past(rd_cnt_o) + 1'b1))); // R10
  AST_RD_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_done |=> $stable(rd_cnt_o)); // R10
  AST_WR_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done |=> (wr_cnt_o == CNT_W'($past(wr_cnt_o) + 1'b1))); // R10
  AST_WR_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_done |=> $stable(wr_cnt_o)); // R10
endmodule

bind wb_cache_ctrl wb_cache_chk #(
  .BLK_W        (BLK_W),
  .BB           (BB),
  .CNT_W        (CNT_W),
  .WRITE_THROUGH(WRITE_THROUGH)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .resp_valid_o(resp_valid_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .mem_ack_i   (mem_ack_i),
  .rd_cnt_o    (rd_cnt_o),
  .wr_cnt_o    (wr_cnt_o)
);

// File: tb/tb_wb_cache_ctrl.sv
module tb_mem_model #(
  parameter int BLK_W = 6,
  parameter int BB    = 4
) (
  input  logic            clk,
  input  logic            req,
  input  logic            we,
  input  logic [BLK_W-1:0] addr,
  input  logic [BB-1:0]   be,
  input  logic [8*BB-1:0] wdata,
  output logic [8*BB-1:0] rdata,
  output logic            ack
);
  localparam int DEPTH = BB << BLK_W;
  logic [7:0] mem [DEPTH];
  int lat = 0;

  initial begin
    ack   = 1'b0;
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i) ^ 8'h5A;
  end

  always @(posedge clk) begin
    ack <= 1'b0;
    if (req && !ack) begin
      if (lat == 1) begin
        lat <= 0;
        ack <= 1'b1;
        for (int b = 0; b < BB; b++) begin
          if (we) begin
            if (be[b]) mem[int'(addr) * BB + b] <= wdata[8*b +: 8];
          end else begin
            rdata[8*b +: 8] <= mem[int'(addr) * BB + b];
          end
        end
      end else begin
        lat <= lat + 1;
      end
    end
  end
endmodule

module tb_wb_cache_ctrl;
  localparam int ADDR_W = 8, OFFSET_W = 2, INDEX_W = 2, CNT_W = 16;
  localparam int BB = 1 << OFFSET_W, BLK_W = ADDR_W - OFFSET_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req_valid [2];
  logic              req_we [2];
  logic [7:0]        req_addr [2];
  logic [7:0]        req_wdata [2];
  logic              req_ready [2];
  logic              resp_valid [2];
  logic [7:0]        resp_rdata [2];
  logic              mem_req [2];
  logic              mem_we [2];
  logic [BLK_W-1:0]  mem_addr [2];
  logic [BB-1:0]     mem_be [2];
  logic [8*BB-1:0]   mem_wdata [2];
  logic [8*BB-1:0]   mem_rdata [2];
  logic              mem_ack [2];
  logic [CNT_W-1:0]  rd_cnt [2];
  logic [CNT_W-1:0]  wr_cnt [2];

  wb_cache_ctrl #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W),
                  .CNT_W(CNT_W), .WRITE_THROUGH(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid[0]), .req_we_i(req_we[0]), .req_addr_i(req_addr[0]),
    .req_wdata_i(req_wdata[0]), .req_ready_o(req_ready[0]),
    .resp_valid_o(resp_valid[0]), .resp_rdata_o(resp_rdata[0]),
    .mem_req_o(mem_req[0]), .mem_we_o(mem_we[0]), .mem_addr_o(mem_addr[0]),
    .mem_be_o(mem_be[0]), .mem_wdata_o(mem_wdata[0]), .mem_rdata_i(mem_rdata[0]),
    .mem_ack_i(mem_ack[0]), .rd_cnt_o(rd_cnt[0]), .wr_cnt_o(wr_cnt[0]));

  wb_cache_ctrl #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W),
                  .CNT_W(CNT_W), .WRITE_THROUGH(1'b1)) dut_wt (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid[1]), .req_we_i(req_we[1]), .req_addr_i(req_addr[1]),
    .req_wdata_i(req_wdata[1]), .req_ready_o(req_ready[1]),
    .resp_valid_o(resp_valid[1]), .resp_rdata_o(resp_rdata[1]),
    .mem_req_o(mem_req[1]), .mem_we_o(mem_we[1]), .mem_addr_o(mem_addr[1]),
    .mem_be_o(mem_be[1]), .mem_wdata_o(mem_wdata[1]), .mem_rdata_i(mem_rdata[1]),
    .mem_ack_i(mem_ack[1]), .rd_cnt_o(rd_cnt[1]), .wr_cnt_o(wr_cnt[1]));

  tb_mem_model #(.BLK_W(BLK_W), .BB(BB)) u_mem0 (
    .clk(clk), .req(mem_req[0]), .we(mem_we[0]), .addr(mem_addr[0]), .be(mem_be[0]),
    .wdata(mem_wdata[0]), .rdata(mem_rdata[0]), .ack(mem_ack[0]));
  tb_mem_model #(.BLK_W(BLK_W), .BB(BB)) u_mem1 (
    .clk(clk), .req(mem_req[1]), .we(mem_we[1]), .addr(mem_addr[1]), .be(mem_be[1]),
    .wdata(mem_wdata[1]), .rdata(mem_rdata[1]), .ack(mem_ack[1]));

  int checks = 0;
  int errors = 0;

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // reference model of the cache state and the processor's memory view
  bit         mv [2][4];
  bit         md [2][4];
  logic [3:0] mt [2][4];
  logic [7:0] pm [2][256];
  int         erd [2];
  int         ewr [2];

  typedef struct {
    logic [7:0] d;
    bit         chk;
    string      r;
  } exp_t;
  exp_t q0 [$];
  exp_t q1 [$];

  // scoreboard monitor
  exp_t it;
  always @(negedge clk) begin
    for (int u = 0; u < 2; u++) begin
      if (resp_valid[u]) begin
        if ((u == 0 && q0.size() == 0) || (u == 1 && q1.size() == 0)) begin
          check("R11 unexpected response", 32'(resp_valid[u]), 32'd0);
        end else begin
          it = (u == 0) ? q0.pop_front() : q1.pop_front();
          if (it.chk) check({it.r, " load data"}, 32'(resp_rdata[u]), 32'(it.d));
        end
      end
    end
  end

  // R9 request stability monitor
  logic             p_req [2];
  logic             p_ack [2];
  logic             p_we [2];
  logic [BLK_W-1:0] p_addr [2];
  initial for (int u = 0; u < 2; u++) begin p_req[u] = 0; p_ack[u] = 0; end
  always @(negedge clk) begin
    for (int u = 0; u < 2; u++) begin
      if (rst_n && p_req[u] && !p_ack[u]) begin
        check("R9 req held", 32'(mem_req[u]), 32'd1);
        check("R9 addr held", 32'(mem_addr[u]), 32'(p_addr[u]));
        check("R9 we held", 32'(mem_we[u]), 32'(p_we[u]));
      end
      p_req[u]  = mem_req[u];
      p_ack[u]  = mem_ack[u];
      p_we[u]   = mem_we[u];
      p_addr[u] = mem_addr[u];
    end
  end

  task automatic access(int u, bit we, logic [7:0] a, logic [7:0] d, string r);
    int  idx = int'(a[3:2]);
    bit  hit = mv[u][idx] && (mt[u][idx] == a[7:4]);
    exp_t e;
    if (!hit) begin
      if (u == 0 && mv[u][idx] && md[u][idx]) ewr[u]++;
      erd[u]++;
      mv[u][idx] = 1'b1;
      md[u][idx] = 1'b0;
      mt[u][idx] = a[7:4];
    end
    if (we) begin
      pm[u][a] = d;
      if (u == 1) ewr[u]++;
      else md[u][idx] = 1'b1;
    end
    e.d = pm[u][a];
    e.chk = !we;
    e.r = r;
    if (u == 0) q0.push_back(e); else q1.push_back(e);
    @(negedge clk);
    req_valid[u] = 1'b1;
    req_we[u]    = we;
    req_addr[u]  = a;
    req_wdata[u] = d;
    while (!req_ready[u]) @(negedge clk);
    @(negedge clk);
    req_valid[u] = 1'b0;
    check("R11 not ready while busy", 32'(req_ready[u]), 32'd0);
    while (!resp_valid[u]) @(negedge clk);
    @(negedge clk);
    check({r, " R10 block reads"}, 32'(rd_cnt[u]), 32'(erd[u]));
    check({r, " R10 memory writes"}, 32'(wr_cnt[u]), 32'(ewr[u]));
  endtask

  task automatic check_mem(int u, logic [7:0] a, logic [7:0] exp, string r);
    logic [7:0] act = (u == 0) ? u_mem0.mem[a] : u_mem1.mem[a];
    check({r, " backing memory"}, 32'(act), 32'(exp));
  endtask

  task automatic run_seq(int u);
    access(u, 0, 8'h01, 8'h00, "R3");
    access(u, 0, 8'h02, 8'h00, "R2");
    access(u, 1, 8'h03, 8'hA5, "R4");
    check_mem(u, 8'h03, (u == 0) ? (8'h03 ^ 8'h5A) : 8'hA5, (u == 0) ? "R4" : "R8");
    access(u, 0, 8'h03, 8'h00, "R4");
    access(u, 0, 8'h41, 8'h00, "R5");
    check_mem(u, 8'h03, 8'hA5, "R5");
    access(u, 0, 8'h42, 8'h00, "R2");
    access(u, 0, 8'h81, 8'h00, "R6");
    access(u, 1, 8'h95, 8'h3C, "R7");
    access(u, 0, 8'h94, 8'h00, "R7");
    access(u, 0, 8'h95, 8'h00, "R7");
    access(u, 1, 8'h17, 8'h66, "R7");
    check_mem(u, 8'h95, 8'h3C, "R5");
    access(u, 1, 8'h16, 8'h77, "R4");
    check_mem(u, 8'h16, (u == 0) ? (8'h16 ^ 8'h5A) : 8'h77, (u == 0) ? "R4" : "R8");
    access(u, 0, 8'h97, 8'h00, "R5");
    check_mem(u, 8'h16, 8'h77, "R5");
    check_mem(u, 8'h17, 8'h66, "R5");
    access(u, 0, 8'h03, 8'h00, "R3");
    for (int i = 0; i < 24; i++) begin
      access(u, (i % 3) == 0, 8'(i * 37 + 5), 8'(i * 11 + 1), (u == 0) ? "R6" : "R8");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int u = 0; u < 2; u++) begin
      req_valid[u] = 0; req_we[u] = 0; req_addr[u] = '0; req_wdata[u] = '0;
      erd[u] = 0; ewr[u] = 0;
      for (int i = 0; i < 4; i++) begin mv[u][i] = 0; md[u][i] = 0; mt[u][i] = '0; end
      for (int i = 0; i < 256; i++) pm[u][i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      check("R1 ready in reset", 32'(req_ready[u]), 32'd1);
      check("R1 no response", 32'(resp_valid[u]), 32'd0);
      check("R1 no memory request", 32'(mem_req[u]), 32'd0);
      check("R1 read count", 32'(rd_cnt[u]), 32'd0);
      check("R1 write count", 32'(wr_cnt[u]), 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    run_seq(0);
    run_seq(1);
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule